// File: doc/BRIEF.md
# Pulse Window Remote-Control Receiver

This block classifies pulses on a serial remote-control input by timing them against a programmable window. A noise filter first cleans the raw input. It takes samples at a selectable rate and passes on a new level only when four samples in a row agree. Edges of the filtered level then drive a 16-bit measurement counter. The counter runs on a prescaled tick derived from the system clock. A configurable start edge clears the counter and starts it again. A second, independently configured finish edge raises a one-cycle interrupt when it arrives while a window flag is set.

The window flag is set when the counter equals the lower bound and cleared when it equals the upper bound. Each start edge also clears it. The edge pairing picks the quantity that is measured: same-direction edges give the pulse period, rising-to-falling gives the high width, and falling-to-rising gives the low width.

The measurement controller has three states. ST_IDLE is the state after reset, where no start edge has been seen and the counter holds. ST_COUNT is the state where the counter advances on each prescaler tick. ST_SAT is the state where the counter is pinned at its all-ones value. The transitions are:
- start: ST_IDLE to ST_COUNT, on a start edge.
- restart: ST_COUNT to ST_COUNT, on a start edge.
- saturate: ST_COUNT to ST_SAT, when a tick arrives at count 16'hFFFE.
- resume: ST_SAT to ST_COUNT, on a start edge.

Top module: `pwin_rx`

## Requirements
- R1: After reset, `cnt` is 0, `win_flag` is 0 and `irq` is 0.
- R2: A start edge on the filtered input sets `cnt` to 0, and counting then restarts from there.
- R3: `win_flag` becomes 1 the cycle after `cnt` equals `win_min`. It becomes 0 the cycle after `cnt` equals `win_max`. A start edge also clears it.
- R4: `irq` is a single-cycle pulse. It is raised only for a finish edge that arrives while `win_flag` is 1.
- R5: Each edge selector is 2 bits wide. 2'b10 selects the rising edge and 2'b01 selects the falling edge. Rising/rising and falling/falling measure the period, falling start with rising finish measures the low width, and rising start with falling finish measures the high width.
- R6: A selector value of 2'b00 or 2'b11 disables its edge. With the start edge disabled, `cnt` holds its value. With the finish edge disabled, no `irq` is produced.
- R7: Filter sampling: with `samp_slow`=0, a sample is taken every clock; with `samp_slow`=1, every 4th clock. A level change reaches the edge logic only after 4 consecutive samples agree, so a 3-clock glitch (fast rate) or a 12-clock glitch (slow rate) produces no edge.
- R8: When `win_min` >= `win_max`, the flag follows whichever match happened last. If both bounds match at once, the clear wins.
- R9: `cnt` saturates at 16'hFFFF and does not wrap.
- R10: `cnt` advances once every 2^`presc_sel` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Raw remote-control input |
| samp_slow | input | 1 | Filter sample rate: 0 = every clock, 1 = every 4th clock |
| presc_sel | input | 2 | Count tick divide exponent (divide by 2^presc_sel) |
| clr_sel | input | 2 | Start edge select: 10 = rising, 01 = falling, 00/11 = off |
| det_sel | input | 2 | Finish edge select, same encoding as clr_sel |
| win_min | input | 16 | Window lower bound (sets flag) |
| win_max | input | 16 | Window upper bound (clears flag) |
| cnt | output | 16 | Measurement counter |
| win_flag | output | 1 | Window flag |
| irq | output | 1 | Interrupt pulse, one clock wide |

## Verification
The bench times pulses just inside and just outside the window in all four edge pairings, at several prescaler ratios. A design with a swapped edge encoding, or with an off-by-one in the flag set or clear, would raise the interrupt for the wrong pulses. It also checks inverted bounds and equal bounds. A design that gave the set priority, or that ignored the order of the matches, would fire for pulses that should be rejected. Glitches of three and twelve clocks are sent at both sample rates. A filter that needs fewer than four agreeing samples would restart the counter, and this shows on `cnt`. A long run drives the counter to its ceiling, where a counter that wraps would reopen the window.

// File: rtl/pwin_pkg.sv
package pwin_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_SAT   = 2'd2
    } meas_st_t;

    localparam logic [1:0] EDGE_RISE = 2'b10;
    localparam logic [1:0] EDGE_FALL = 2'b01;

    function automatic logic edge_hit(input logic [1:0] sel, input logic rise, input logic fall);
        return ((sel == EDGE_RISE) && rise) || ((sel == EDGE_FALL) && fall);
    endfunction

    function automatic logic edge_on(input logic [1:0] sel);
        return (sel == EDGE_RISE) || (sel == EDGE_FALL);
    endfunction

endpackage

// File: rtl/pwin_filter.sv
module pwin_filter #(
    parameter int SLOW_DIV = 4,
    parameter int NSAMP    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic samp_slow,
    output logic rise,
    output logic fall
);
    localparam int DW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

    logic [DW-1:0]    div_q;
    logic [1:0]       sync_q;
    logic [NSAMP-1:0] sh_q;
    logic [NSAMP-1:0] sh_nxt;
    logic             lvl_q;
    logic             lvl_d;
    logic             tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            div_q <= '0;
        else if (div_q == DW'(SLOW_DIV - 1))   div_q <= '0;
        else                                   div_q <= div_q + 1'b1;
    end

    assign tick   = samp_slow ? (div_q == '0) : 1'b1;
    assign sh_nxt = {sh_q[NSAMP-2:0], sync_q[1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            sh_q   <= '0;
            lvl_q  <= 1'b0;
            lvl_d  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], raw};
            lvl_d  <= lvl_q;
            if (tick) begin
                sh_q <= sh_nxt;
                if (&sh_nxt)       lvl_q <= 1'b1;
                else if (~|sh_nxt) lvl_q <= 1'b0;
            end
        end
    end

    assign rise = lvl_q & ~lvl_d;
    assign fall = ~lvl_q & lvl_d;

    // R7
    lvl_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q != $past(lvl_q)) |-> $past(tick));

    // R7
    lvl_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl_q) |-> $past(sync_q[1]));

endmodule

// File: rtl/pwin_presc.sv
module pwin_presc #(
    parameter int PSW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [PSW-1:0] sel,
    output logic           tick
);
    localparam int PCW = (1 << PSW) - 1;

    logic [PCW-1:0] pc_q;
    logic [PCW-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_q + 1'b1;
    end

    always_comb mask = PCW'((1 << sel) - 1);

    assign tick = ((pc_q & mask) == '0);

endmodule

// File: rtl/pwin_meas.sv
module pwin_meas
    import pwin_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rise,
    input  logic          fall,
    input  logic [1:0]    clr_sel,
    input  logic [1:0]    det_sel,
    input  logic [CW-1:0] win_min,
    input  logic [CW-1:0] win_max,
    output logic [CW-1:0] cnt,
    output logic          win_flag,
    output logic          irq
);
    localparam logic [CW-1:0] TOP = '1;

    meas_st_t      st_q, st_nxt;
    logic [CW-1:0] cnt_q;
    logic          flag_q;
    logic          irq_q;
    logic          clr_evt;
    logic          det_evt;
    logic          clr_en;

    assign clr_evt = edge_hit(clr_sel, rise, fall);
    assign det_evt = edge_hit(det_sel, rise, fall);
    assign clr_en  = edge_on(clr_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE:  if (clr_evt) st_nxt = ST_COUNT;
            ST_COUNT: begin
                if (clr_evt)                                     st_nxt = ST_COUNT;
                else if (tick && clr_en && cnt_q == TOP - 1'b1) st_nxt = ST_SAT;
            end
            ST_SAT:   if (clr_evt) st_nxt = ST_COUNT;
            default:  st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= det_evt & flag_q;
            if (clr_evt) begin
                cnt_q  <= '0;
                flag_q <= 1'b0;
            end else begin
                if (st_q == ST_COUNT && tick && clr_en) cnt_q <= cnt_q + 1'b1;
                if (st_q != ST_IDLE) begin
                    if (cnt_q == win_max)      flag_q <= 1'b0;
                    else if (cnt_q == win_min) flag_q <= 1'b1;
                end
            end
        end
    end

    assign cnt      = cnt_q;
    assign win_flag = flag_q;
    assign irq      = irq_q;

    // R2
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_evt |=> (cnt_q == '0));

    // R3
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_evt |=> !flag_q);

    // R4
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    // R4
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(flag_q));

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == TOP && !clr_evt) |=> (cnt_q == TOP));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/pwin_rx.sv
module pwin_rx #(
    parameter int CW       = 16,
    parameter int PSW      = 2,
    parameter int SLOW_DIV = 4,
    parameter int NSAMP    = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rx_in,
    input  logic           samp_slow,
    input  logic [PSW-1:0] presc_sel,
    input  logic [1:0]     clr_sel,
    input  logic [1:0]     det_sel,
    input  logic [CW-1:0]  win_min,
    input  logic [CW-1:0]  win_max,
    output logic [CW-1:0]  cnt,
    output logic           win_flag,
    output logic           irq
);
    logic f_rise;
    logic f_fall;
    logic c_tick;

    pwin_filter #(.SLOW_DIV(SLOW_DIV), .NSAMP(NSAMP)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw       (rx_in),
        .samp_slow (samp_slow),
        .rise      (f_rise),
        .fall      (f_fall)
    );

    pwin_presc #(.PSW(PSW)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (presc_sel),
        .tick  (c_tick)
    );

    pwin_meas #(.CW(CW)) u_meas (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (c_tick),
        .rise     (f_rise),
        .fall     (f_fall),
        .clr_sel  (clr_sel),
        .det_sel  (det_sel),
        .win_min  (win_min),
        .win_max  (win_max),
        .cnt      (cnt),
        .win_flag (win_flag),
        .irq      (irq)
    );

    // R1
    rst_state_chk: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0 && !win_flag && !irq));

endmodule

// File: tb/sim_pwin_rx.sv
module sim_pwin_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_in = 1'b0;
    logic        samp_slow = 1'b0;
    logic [1:0]  presc_sel = 2'd0;
    logic [1:0]  clr_sel = 2'b10;
    logic [1:0]  det_sel = 2'b10;
    logic [15:0] win_min = 16'd50;
    logic [15:0] win_max = 16'd100;
    logic [15:0] cnt;
    logic        win_flag;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    int irq_hi = 0;
    bit done = 1'b0;

    localparam int GAP = 1400;

    always #10 clk = ~clk;

    pwin_rx u0 (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .samp_slow(samp_slow),
        .presc_sel(presc_sel), .clr_sel(clr_sel), .det_sel(det_sel),
        .win_min(win_min), .win_max(win_max),
        .cnt(cnt), .win_flag(win_flag), .irq(irq)
    );

    always @(negedge clk) if (irq) irq_hi++;

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_irq(input int w, input int lo, input int hi);
        if (lo >= hi) return (w > lo) ? 1 : 0;
        return (w > lo && w < hi) ? 1 : 0;
    endfunction

    // mode: 0 rise/rise period, 1 fall/fall period, 2 low width, 3 high width
    task automatic trial(input int mode, input int w, input int dsel);
        int d;
        d = w * (1 << dsel);
        presc_sel = 2'(dsel);
        case (mode)
            0: begin clr_sel = 2'b10; det_sel = 2'b10; end
            1: begin clr_sel = 2'b01; det_sel = 2'b01; end
            2: begin clr_sel = 2'b01; det_sel = 2'b10; end
            default: begin clr_sel = 2'b10; det_sel = 2'b01; end
        endcase
        rx_in = (mode == 1 || mode == 2);
        wclk(GAP);
        irq_hi = 0;
        case (mode)
            0: begin rx_in = 1; wclk(d/2); rx_in = 0; wclk(d - d/2); rx_in = 1; end
            1: begin rx_in = 0; wclk(d/2); rx_in = 1; wclk(d - d/2); rx_in = 0; end
            2: begin rx_in = 0; wclk(d); rx_in = 1; end
            default: begin rx_in = 1; wclk(d); rx_in = 0; end
        endcase
        wclk(30);
    endtask

    initial begin
        int c0;
        void'($urandom(32'd20240611));
        wclk(3);
        // R1 reset state
        chk(cnt == 0, "R1 cnt", cnt, 0);
        chk(win_flag == 0, "R1 flag", win_flag, 0);
        chk(irq == 0, "R1 irq", irq, 0);
        rst_n = 1'b1;
        wclk(5);

        // R10 / R2: tick rate per prescaler setting
        for (int s = 0; s < 4; s++) begin
            presc_sel = 2'(s);
            clr_sel = 2'b10; det_sel = 2'b00;
            rx_in = 0; wclk(20);
            rx_in = 1; wclk(6 + 100 * (1 << s));
            chk(cnt >= 98 && cnt <= 102, "R10 R2 tick rate", cnt, 100);
        end

        // R3 flag window timing
        presc_sel = 0; win_min = 50; win_max = 100;
        rx_in = 0; wclk(20);
        rx_in = 1; wclk(36);
        chk(win_flag == 0, "R3 before min", win_flag, 0);
        wclk(45);
        chk(win_flag == 1, "R3 inside", win_flag, 1);
        wclk(55);
        chk(win_flag == 0, "R3 after max", win_flag, 0);

        // R3 start edge clears flag
        win_min = 10; win_max = 1000;
        rx_in = 0; wclk(20);
        rx_in = 1; wclk(50);
        chk(win_flag == 1, "R3 flag set", win_flag, 1);
        rx_in = 0; wclk(10);
        rx_in = 1; wclk(10);
        chk(win_flag == 0, "R3 cleared by start edge", win_flag, 0);
        chk(cnt < 10, "R2 restart", cnt, 4);

        // R6 start edge disabled holds count
        for (int k = 0; k < 2; k++) begin
            clr_sel = 2'b10;
            rx_in = 0; wclk(20);
            rx_in = 1; wclk(40);
            clr_sel = (k == 0) ? 2'b00 : 2'b11;
            wclk(2);
            c0 = cnt;
            rx_in = 0; wclk(20); rx_in = 1; wclk(20);
            chk(cnt == c0, "R6 hold with start off", cnt, c0);
        end

        // R6 finish edge disabled: no irq
        win_min = 10; win_max = 200;
        for (int k = 0; k < 2; k++) begin
            rx_in = 0; clr_sel = 2'b10; det_sel = (k == 0) ? 2'b00 : 2'b11;
            wclk(GAP); irq_hi = 0;
            rx_in = 1; wclk(100); rx_in = 0; wclk(30);
            chk(irq_hi == 0, "R6 no irq with finish off", irq_hi, 0);
        end

        // R7 glitch filtering
        clr_sel = 2'b10; det_sel = 2'b00; presc_sel = 0;
        samp_slow = 0; rx_in = 0; wclk(20);
        rx_in = 1; wclk(20); rx_in = 0; wclk(100);
        c0 = cnt;
        rx_in = 1; wclk(3); rx_in = 0; wclk(20);
        chk(cnt > c0, "R7 3-clock glitch fast rate ignored", cnt, c0 + 23);
        samp_slow = 1; wclk(100);
        c0 = cnt;
        rx_in = 1; wclk(12); rx_in = 0; wclk(40);
        chk(cnt > c0, "R7 12-clock glitch slow rate ignored", cnt, c0 + 52);
        samp_slow = 0; wclk(40);
        rx_in = 1; wclk(12); rx_in = 0; wclk(20);
        chk(cnt < 40, "R7 12-clock pulse fast rate passes", cnt, 26);

        // R8 inverted and equal bounds, high width mode
        win_min = 200; win_max = 100;
        trial(3, 150, 0);
        chk(irq_hi == 0, "R8 inverted bounds short", irq_hi, 0);
        trial(3, 300, 0);
        chk(irq_hi == 1, "R8 inverted bounds long", irq_hi, 1);
        chk(win_flag == 1, "R8 flag follows last match", win_flag, 1);
        win_min = 100; win_max = 100;
        trial(3, 150, 0);
        chk(irq_hi == 0, "R8 equal bounds clear wins", irq_hi, 0);

        // R4 R5 constrained random trials over all edge pairings
        for (int i = 0; i < 24; i++) begin
            int mode, ds, lo, hi, w, e;
            mode = int'($urandom % 4);
            ds   = int'($urandom % 3);
            lo   = 8 + int'($urandom % 113);
            hi   = lo + 8 + int'($urandom % 140);
            do w = 16 + int'($urandom % 285);
            while ((w - lo <= 2 && lo - w <= 2) || (w - hi <= 2 && hi - w <= 2));
            if (i < 4) mode = i;
            win_min = 16'(lo); win_max = 16'(hi);
            e = exp_irq(w, lo, hi);
            trial(mode, w, ds);
            chk(irq_hi == e, $sformatf("R5 R4 mode %0d w %0d win %0d..%0d", mode, w, lo, hi), irq_hi, e);
        end

        // R9 saturation
        presc_sel = 0; clr_sel = 2'b10; det_sel = 2'b00;
        win_min = 10; win_max = 16'hFFFF;
        rx_in = 0; wclk(20);
        rx_in = 1; wclk(65600);
        chk(cnt == 16'hFFFF, "R9 saturated", cnt, 16'hFFFF);
        chk(win_flag == 0, "R3 flag cleared at max", win_flag, 0);
        wclk(200);
        chk(cnt == 16'hFFFF, "R9 no wrap", cnt, 16'hFFFF);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule